// File: doc/BRIEF.md
# Byte-Serial Block Staging Buffer

This block connects a byte-wide host stream to a cipher engine that works on whole 128-bit blocks. Host bytes arrive over a valid/ready input stream and are placed into a block register, the first byte at the most significant end. The block closes in one of two ways: the sixteenth byte arrives, or a byte arrives with the end-of-block flag set. When it closes, the block issues a one-cycle start pulse to the engine together with the number of bytes that were really received. Any low-order bytes that were not received read as zero.

When the engine reports completion, its 128-bit result is captured and streamed back to the host as sixteen bytes, most significant byte first, over a valid/ready output stream. Loading and unloading form one request cycle. The input stream stays closed from the start pulse until the last result byte has been taken.

Back-pressure rules are as follows. An input byte is taken only on a cycle where `in_valid` and `in_ready` are both high. An output byte is taken only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, a pending output byte and its valid flag hold steady.

Top module: `blk_byte_stager`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `eng_start` is 0.
- R2: The k-th accepted byte of a block (k counted from 0) lands in bits [127-8k : 120-8k] of `eng_block`. After the 16th accepted byte, `eng_start` is high in the following cycle and `eng_count` reads 16.
- R3: A byte accepted with `in_last`=1 closes the block after n bytes (1 ≤ n ≤ 16). In the following cycle `eng_start` is high, `eng_count` equals n, and the unfilled low-order bytes of `eng_block` are zero.
- R4: `eng_start` lasts exactly one cycle per block.
- R5: `in_ready` is low from the start pulse until the final output byte is accepted. Input offered in that window has no effect on `eng_block`, and `eng_block` stays stable.
- R6: `eng_done` sampled while waiting for the engine captures `eng_result`. `out_valid` goes high in the next cycle. Later changes on `eng_result` have no effect.
- R7: The output sends 16 bytes, the most significant byte of the captured result first. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R8: In the cycle after the 16th output byte is accepted, `in_ready` is 1 and `out_valid` is 0. `eng_done` has no effect while the block is loading.
- R9: Every new block starts from an all-zero register, so no byte of an earlier block appears in a later partial block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Host input byte valid |
| in_data | input | 8 | Host input byte |
| in_last | input | 1 | Marks the final byte of a block |
| in_ready | output | 1 | Buffer accepts an input byte |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_block | output | 128 | Assembled block, first byte in the top byte |
| eng_count | output | 5 | Number of received bytes, 1 to 16 |
| eng_done | input | 1 | Engine result ready |
| eng_result | input | 128 | Engine result block |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Host takes the output byte |

## Verification
The bound checker watches several properties on every cycle:
- the single-cycle start pulse and the legal byte count;
- the closed input window and the frozen block register while the engine is busy;
- the reopening of input after the sixteenth output transfer;
- the output holding steady under back-pressure.

Byte placement, zero fill, byte order of the output, and the fact that stray input and stray completion pulses change nothing depend on data values. Only the bench's scenarios can show these. The bench runs full, partial and single-byte blocks with random gaps and stalls, and compares the results against block and result values that it computes itself.

// File: rtl/stager_pkg.sv
package stager_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRAIN = 2'd2
  } stage_e;
endpackage

// File: rtl/stager_ctrl.sv
module stager_ctrl
  import stager_pkg::*;
#(
  parameter int LANES = 16,
  localparam int IDX_W = $clog2(LANES),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             eng_done,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             blk_clear,
  output logic             cap_en,
  output logic             shift_en,
  output logic             eng_start,
  output logic [CNT_W-1:0] eng_count
);
  stage_e           state;
  logic [IDX_W-1:0] in_idx;
  logic [IDX_W-1:0] out_idx;
  logic             in_fire, in_close, out_fire, out_close;

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_DRAIN);
  assign in_fire   = in_valid && in_ready;
  assign in_close  = in_fire && (in_last || in_idx == IDX_W'(LANES - 1));
  assign out_fire  = out_valid && out_ready;
  assign out_close = out_fire && (out_idx == IDX_W'(LANES - 1));

  assign wr_en     = in_fire;
  assign wr_idx    = in_idx;
  assign blk_clear = out_close;
  assign cap_en    = (state == ST_WAIT) && eng_done;
  assign shift_en  = out_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_LOAD;
      in_idx    <= '0;
      out_idx   <= '0;
      eng_start <= 1'b0;
      eng_count <= '0;
    end else begin
      eng_start <= in_close;
      unique case (state)
        ST_LOAD: begin
          if (in_close) begin
            state     <= ST_WAIT;
            eng_count <= CNT_W'(in_idx) + CNT_W'(1);
            in_idx    <= '0;
          end else if (in_fire) begin
            in_idx <= in_idx + IDX_W'(1);
          end
        end
        ST_WAIT: begin
          if (eng_done) begin
            state   <= ST_DRAIN;
            out_idx <= '0;
          end
        end
        ST_DRAIN: begin
          if (out_close) begin
            state   <= ST_LOAD;
            out_idx <= '0;
          end else if (out_fire) begin
            out_idx <= out_idx + IDX_W'(1);
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/stager_collect.sv
module stager_collect #(
  parameter int LANES  = 16,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(LANES),
  localparam int BLK_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] din,
  input  logic              clear,
  output logic [BLK_W-1:0]  blk
);
  // lane LANES-1 is the top byte and receives the first byte of a block
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (clear)
        lane_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(LANES - 1 - g))
        lane_q <= din;
    end
    assign blk[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/stager_emit.sv
module stager_emit #(
  parameter int LANES  = 16,
  parameter int BYTE_W = 8,
  localparam int BLK_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [BLK_W-1:0]  result,
  input  logic              shift_en,
  output logic [BYTE_W-1:0] dout
);
  logic [BLK_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sh_q <= '0;
    else if (cap_en)
      sh_q <= result;
    else if (shift_en)
      sh_q <= {sh_q[BLK_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
  end

  assign dout = sh_q[BLK_W-1 -: BYTE_W];
endmodule

// File: rtl/blk_byte_stager.sv
module blk_byte_stager #(
  parameter int LANES  = 16,
  parameter int BYTE_W = 8,
  localparam int BLK_W = LANES * BYTE_W,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              eng_start,
  output logic [BLK_W-1:0]  eng_block,
  output logic [CNT_W-1:0]  eng_count,
  input  logic              eng_done,
  input  logic [BLK_W-1:0]  eng_result,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);
  localparam int IDX_W = $clog2(LANES);

  logic             wr_en, blk_clear, cap_en, shift_en;
  logic [IDX_W-1:0] wr_idx;

  stager_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .eng_done  (eng_done),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .blk_clear (blk_clear),
    .cap_en    (cap_en),
    .shift_en  (shift_en),
    .eng_start (eng_start),
    .eng_count (eng_count)
  );

  stager_collect #(.LANES(LANES), .BYTE_W(BYTE_W)) u_collect (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .din    (in_data),
    .clear  (blk_clear),
    .blk    (eng_block)
  );

  stager_emit #(.LANES(LANES), .BYTE_W(BYTE_W)) u_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .result   (eng_result),
    .shift_en (shift_en),
    .dout     (out_data)
  );
endmodule

// File: rtl/stager_checker.sv
module stager_checker #(
  parameter int LANES  = 16,
  parameter int BYTE_W = 8,
  localparam int BLK_W = LANES * BYTE_W,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int IDX_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              eng_start,
  input logic [BLK_W-1:0]  eng_block,
  input logic [CNT_W-1:0]  eng_count,
  input logic              eng_done,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_data,
  input logic              out_ready
);
  logic [IDX_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen_q <= '0;
    else if (out_valid && out_ready)
      seen_q <= (seen_q == IDX_W'(LANES - 1)) ? '0 : seen_q + IDX_W'(1);
  end

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_count != '0 && eng_count <= CNT_W'(LANES)));

  assert_closed_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !in_ready);

  assert_block_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready)) |-> $stable(eng_block));

  assert_phase_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !out_valid && eng_done) |=> out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_reopen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && seen_q == IDX_W'(LANES - 1)) |=> (in_ready && !out_valid));
endmodule

bind blk_byte_stager stager_checker #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .eng_start (eng_start),
  .eng_block (eng_block),
  .eng_count (eng_count),
  .eng_done  (eng_done),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready)
);

// File: tb/blk_byte_stager_tb.sv
module blk_byte_stager_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [7:0]   in_data = '0;
  logic         in_last = 1'b0;
  logic         in_ready;
  logic         eng_start;
  logic [127:0] eng_block;
  logic [4:0]   eng_count;
  logic         eng_done = 1'b0;
  logic [127:0] eng_result = '0;
  logic         out_valid;
  logic [7:0]   out_data;
  logic         out_ready = 1'b0;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_byte_stager u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .eng_start(eng_start), .eng_block(eng_block), .eng_count(eng_count),
    .eng_done(eng_done), .eng_result(eng_result),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] engine_fn(input logic [127:0] b);
    return {b[63:0], b[127:64]} ^ 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
  endfunction

  task automatic push(input logic [7:0] b, input bit last);
    int gap = $urandom % 3;
    for (int g = 0; g < gap; g++) @(negedge clk);
    check(in_ready === 1'b1, "R5 ready while loading", {127'd0, in_ready}, 128'd1);
    in_valid = 1'b1; in_data = b; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_block(input int n, input bit use_last, input bit poke, input string tag);
    logic [7:0]   bytes [16];
    logic [127:0] exp_blk = '0;
    logic [127:0] res;
    int           dly;
    for (int i = 0; i < 16; i++) bytes[i] = 8'($urandom);
    for (int i = 0; i < n; i++) exp_blk[(15-i)*8 +: 8] = bytes[i];
    for (int i = 0; i < n; i++) push(bytes[i], use_last && (i == n-1));
    // cycle after the closing byte
    check(eng_start === 1'b1, "R4 start after close", {127'd0, eng_start}, 128'd1);
    check(eng_block === exp_blk, tag, eng_block, exp_blk);
    check(eng_count === 5'(n), "R3 byte count", {123'd0, eng_count}, 128'(n));
    check(in_ready === 1'b0, "R5 closed on start", {127'd0, in_ready}, 128'd0);
    @(negedge clk);
    check(eng_start === 1'b0, "R4 single pulse", {127'd0, eng_start}, 128'd0);
    if (poke) begin
      in_valid = 1'b1; in_data = 8'hEE; in_last = 1'b1;
      for (int k = 0; k < 3; k++) @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      check(in_ready === 1'b0, "R5 stays closed", {127'd0, in_ready}, 128'd0);
      check(eng_block === exp_blk, "R5 stray input ignored", eng_block, exp_blk);
    end
    dly = $urandom % 4;
    for (int k = 0; k < dly; k++) @(negedge clk);
    res = engine_fn(exp_blk);
    eng_done = 1'b1; eng_result = res;
    @(negedge clk);
    eng_done = 1'b0; eng_result = {$urandom, $urandom, $urandom, $urandom};
    check(out_valid === 1'b1, "R6 valid after done", {127'd0, out_valid}, 128'd1);
    for (int i = 0; i < 16; i++) begin
      int stall = $urandom % 3;
      for (int s = 0; s < stall; s++) begin
        out_ready = 1'b0;
        check(out_valid === 1'b1 && out_data === res[(15-i)*8 +: 8], "R7 hold under stall",
              {119'd0, out_valid, out_data}, {119'd1, res[(15-i)*8 +: 8]});
        @(negedge clk);
      end
      check(out_data === res[(15-i)*8 +: 8], "R7 byte order", {120'd0, out_data},
            {120'd0, res[(15-i)*8 +: 8]});
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    check(in_ready === 1'b1 && out_valid === 1'b0, "R8 reopen after last byte",
          {126'd0, in_ready, out_valid}, 128'd2);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0 && eng_start === 1'b0, "R1 reset state",
          {125'd0, in_ready, out_valid, eng_start}, 128'd4);
    // completion pulse while loading must do nothing
    eng_done = 1'b1; eng_result = '1;
    @(negedge clk);
    eng_done = 1'b0;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R8 done ignored while loading",
          {126'd0, in_ready, out_valid}, 128'd2);
    run_block(16, 1'b0, 1'b1, "R2 full block placement");
    run_block(1, 1'b1, 1'b0, "R9 single byte zero fill");
    run_block(16, 1'b1, 1'b0, "R2 full block with flag");
    run_block(7, 1'b1, 1'b1, "R3 partial zero fill");
    for (int t = 0; t < 20; t++) begin
      int n = 1 + ($urandom % 16);
      run_block(n, (n < 16) ? 1'b1 : 1'($urandom), 1'($urandom), "R9 random block");
    end
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule